// File: doc/BRIEF.md
# USB IN Endpoint Transaction Engine

This block carries out the device side of IN transactions for a single IN endpoint of a full-speed USB function. Firmware loads a packet buffer and a byte count, sets the control bits, and then clears the NACK bit to arm the endpoint. The block gets IN tokens that are already decoded and addressed to this endpoint. Depending on the control bits it answers with a STALL handshake, a NAK handshake, or the buffered data packet. The data packet carries a DATA0 or DATA1 PID, chosen by the TOGGLE bit. After a data packet the block waits for the host's ACK or for a timeout.

When the host acknowledges, the block inverts TOGGLE and sets NACK, which passes the buffer back to firmware. It also raises a sticky interrupt flag. When no handshake arrives, nothing changes, so the next IN token sends the identical packet again. A status stage is a zero-length DATA1 packet: firmware produces it by setting TOGGLE to 1 with a byte count of 0.

Output bytes go out on a valid/ready byte stream. The PID byte comes first. Serial encoding, CRC and token decoding happen outside this block.

Top module: `usb_in_ep_engine`

## Requirements
- R1: After a synchronous reset the control readback `ep_ctrl_o` is 5'b00001, meaning only NACK is set. `int_flag_o`, `irq_o` and `tx_valid` are all 0. The control bit positions are: bit0 NACK, bit1 STALL, bit2 TOGGLE, bit3 interrupt enable, bit4 endpoint enable.
- R2: Firmware writes take one cycle with `reg_we`=1. `reg_sel` selects the target: 0 writes the control bits from `reg_wdata[4:0]`, 1 writes the byte count, 2 writes buffer byte `reg_idx`, and 3 with `reg_wdata[0]`=1 clears the interrupt flag.
- R3: While endpoint enable is 0, an IN token is ignored. Nothing is transmitted and no state changes.
- R4: On an IN token with STALL=1, the block sends a single byte 8'h1E with `tx_last`=1. This happens whatever the value of NACK.
- R5: On an IN token with STALL=0 and NACK=1, the block sends a single byte 8'h5A with `tx_last`=1. The control bits do not change.
- R6: On an IN token with the endpoint armed, the block sends a PID byte followed by the buffer bytes from index 0 up to count-1. The PID is 8'hC3 when TOGGLE=0 and 8'h4B when TOGGLE=1. `tx_last` marks the final byte.
- R7: For any response, the first byte is valid, with `tx_valid`=1, on the cycle after the token is sampled. Each byte is held until `tx_ready` is 1.
- R8: If `hs_ack` is sampled during the handshake wait, then one cycle later TOGGLE is inverted, NACK is 1 and the interrupt flag is 1.
- R9: If `hs_timeout` ends the wait instead, the control bits and the flag do not change. The next IN token resends the identical packet with the same PID.
- R10: With TOGGLE=1 and a count of 0, the block sends the single byte 8'h4B with `tx_last`=1. This is the status stage.
- R11: The interrupt flag stays set until firmware clears it. `irq_o` equals the flag ANDed with interrupt enable.
- R12: A byte count written above MAX_PKT is limited to MAX_PKT.
- R13: `hs_ack` and `hs_timeout` have no effect outside the handshake wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Firmware write strobe |
| reg_sel | input | 2 | Write target: 0 control, 1 count, 2 buffer, 3 interrupt clear |
| reg_idx | input | IDX_W | Buffer byte index |
| reg_wdata | input | 8 | Write data |
| tok_in | input | 1 | Decoded IN token for this endpoint (one-cycle pulse) |
| hs_ack | input | 1 | Host ACK handshake received |
| hs_timeout | input | 1 | Handshake wait expired |
| tx_ready | input | 1 | Transmitter accepts the current byte |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_data | output | 8 | PID or payload byte |
| tx_last | output | 1 | Final byte of the packet |
| ep_ctrl_o | output | 5 | Control bits readback |
| int_flag_o | output | 1 | Sticky endpoint interrupt flag |
| irq_o | output | 1 | Interrupt output gated by enable |

## Verification
The first byte of any response is due on the cycle after the edge that samples the token. The bench checks `tx_valid` and `tx_data` right after that edge. All bytes are collected at the falling edge, and only when valid and ready are both high, so backpressure from random `tx_ready` never shifts the expected content. Control bits and the flag are due one cycle after the handshake is sampled. The bench waits exactly one edge after driving `hs_ack` or `hs_timeout`, and before reading the readback ports. Ignored stimuli are judged over a 20-cycle window with no packet observed.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

    localparam logic [7:0] PID_DATA0 = 8'hC3;
    localparam logic [7:0] PID_DATA1 = 8'h4B;
    localparam logic [7:0] PID_NAK   = 8'h5A;
    localparam logic [7:0] PID_STALL = 8'h1E;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HSHK,
        ST_PID,
        ST_DATA,
        ST_WAIT
    } ep_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_BUF    = 2'd2,
        SEL_INTCLR = 2'd3
    } reg_sel_e;

    // nack at bit 0 up to enable at bit 4
    typedef struct packed {
        logic en;
        logic ie;
        logic toggle;
        logic stall;
        logic nack;
    } ep_ctrl_t;

    localparam ep_ctrl_t CTRL_RESET = '{en: 1'b0, ie: 1'b0, toggle: 1'b0,
                                        stall: 1'b0, nack: 1'b1};

    function automatic logic [7:0] data_pid(input logic tog);
        return tog ? PID_DATA1 : PID_DATA0;
    endfunction

endpackage

// File: rtl/usb_in_ep_regs.sv
module usb_in_ep_regs
    import usb_in_ep_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int IDX_W   = $clog2(MAX_PKT),
    parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [7:0]       reg_wdata,
    input  logic             hw_ack,
    input  logic [IDX_W-1:0] rd_idx,
    output ep_ctrl_t         ctrl,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [7:0]       rd_byte,
    output logic             int_flag
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PKT);

    logic [7:0] mem [MAX_PKT];

    logic wr_ctrl, wr_cnt, wr_buf, wr_clr;
    assign wr_ctrl = reg_we && (reg_sel_e'(reg_sel) == SEL_CTRL);
    assign wr_cnt  = reg_we && (reg_sel_e'(reg_sel) == SEL_COUNT);
    assign wr_buf  = reg_we && (reg_sel_e'(reg_sel) == SEL_BUF);
    assign wr_clr  = reg_we && (reg_sel_e'(reg_sel) == SEL_INTCLR) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (wr_buf) mem[reg_idx] <= reg_wdata;
    end

    assign rd_byte = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_cnt <= '0;
        end else if (wr_cnt) begin
            if (reg_wdata > 8'(MAX_PKT)) byte_cnt <= CNT_MAX;
            else                         byte_cnt <= CNT_W'(reg_wdata);
        end
    end

    // hardware completion wins over a same-cycle firmware write
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else begin
            if (wr_ctrl) ctrl <= ep_ctrl_t'(reg_wdata[4:0]);
            if (hw_ack) begin
                ctrl.toggle <= ~ctrl.toggle;
                ctrl.nack   <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         int_flag <= 1'b0;
        else if (hw_ack) int_flag <= 1'b1;
        else if (wr_clr) int_flag <= 1'b0;
    end

    AST_ACK_HANDOVER: assert property (@(posedge clk) disable iff (rst)
        hw_ack |=> (ctrl.nack && int_flag && (ctrl.toggle != $past(ctrl.toggle)))); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (int_flag && !wr_clr) |=> int_flag); // R11

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (byte_cnt <= CNT_MAX)); // R12

endmodule

// File: rtl/usb_in_ep_seq.sv
module usb_in_ep_seq
    import usb_in_ep_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ep_en,
    input  logic             ep_stall,
    input  logic             ep_nack,
    input  logic             ep_toggle,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [7:0]       rd_byte,
    input  logic             tok_in,
    input  logic             hs_ack,
    input  logic             hs_timeout,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic [IDX_W-1:0] rd_idx,
    output logic             hw_ack
);

    ep_state_e        st_q;
    logic [7:0]       pid_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] idx_q;
    logic             data_end;

    assign data_end = (idx_q == len_q - CNT_W'(1));
    assign rd_idx   = idx_q[IDX_W-1:0];
    assign hw_ack   = (st_q == ST_WAIT) && hs_ack;

    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        tx_last  = 1'b0;
        unique case (st_q)
            ST_HSHK: begin
                tx_valid = 1'b1;
                tx_data  = pid_q;
                tx_last  = 1'b1;
            end
            ST_PID: begin
                tx_valid = 1'b1;
                tx_data  = pid_q;
                tx_last  = (len_q == '0);
            end
            ST_DATA: begin
                tx_valid = 1'b1;
                tx_data  = rd_byte;
                tx_last  = data_end;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            pid_q <= 8'h00;
            len_q <= '0;
            idx_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (tok_in && ep_en) begin
                        if (ep_stall) begin
                            pid_q <= PID_STALL;
                            st_q  <= ST_HSHK;
                        end else if (ep_nack) begin
                            pid_q <= PID_NAK;
                            st_q  <= ST_HSHK;
                        end else begin
                            pid_q <= data_pid(ep_toggle);
                            len_q <= byte_cnt;
                            idx_q <= '0;
                            st_q  <= ST_PID;
                        end
                    end
                end
                ST_HSHK: if (tx_ready) st_q <= ST_IDLE;
                ST_PID: begin
                    if (tx_ready) st_q <= (len_q == '0) ? ST_WAIT : ST_DATA;
                end
                ST_DATA: begin
                    if (tx_ready) begin
                        if (data_end) st_q <= ST_WAIT;
                        else          idx_q <= idx_q + CNT_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (hs_ack || hs_timeout) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && tok_in && !ep_en) |=> !tx_valid); // R3

    AST_STALL_FIRST: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && tok_in && ep_en && ep_stall)
        |=> (tx_valid && tx_last && tx_data == PID_STALL)); // R4

    AST_NAK_REPLY: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && tok_in && ep_en && !ep_stall && ep_nack)
        |=> (tx_valid && tx_last && tx_data == PID_NAK)); // R5

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> tx_valid); // R7

    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_WAIT) |-> !hw_ack); // R13

endmodule

// File: rtl/usb_in_ep_engine.sv
module usb_in_ep_engine
    import usb_in_ep_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int IDX_W   = $clog2(MAX_PKT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [7:0]       reg_wdata,
    input  logic             tok_in,
    input  logic             hs_ack,
    input  logic             hs_timeout,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic [4:0]       ep_ctrl_o,
    output logic             int_flag_o,
    output logic             irq_o
);

    localparam int CNT_W = $clog2(MAX_PKT + 1);

    ep_ctrl_t         ctrl;
    logic [CNT_W-1:0] byte_cnt;
    logic [7:0]       rd_byte;
    logic [IDX_W-1:0] rd_idx;
    logic             hw_ack;
    logic             int_flag;

    usb_in_ep_regs #(
        .MAX_PKT (MAX_PKT),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .hw_ack    (hw_ack),
        .rd_idx    (rd_idx),
        .ctrl      (ctrl),
        .byte_cnt  (byte_cnt),
        .rd_byte   (rd_byte),
        .int_flag  (int_flag)
    );

    usb_in_ep_seq #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ep_en      (ctrl.en),
        .ep_stall   (ctrl.stall),
        .ep_nack    (ctrl.nack),
        .ep_toggle  (ctrl.toggle),
        .byte_cnt   (byte_cnt),
        .rd_byte    (rd_byte),
        .tok_in     (tok_in),
        .hs_ack     (hs_ack),
        .hs_timeout (hs_timeout),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .rd_idx     (rd_idx),
        .hw_ack     (hw_ack)
    );

    assign ep_ctrl_o  = ctrl;
    assign int_flag_o = int_flag;
    assign irq_o      = int_flag & ctrl.ie;

endmodule

// File: tb/sim_usb_in_ep_engine.sv
`timescale 1ns/1ps
module sim_usb_in_ep_engine;

    localparam int MAX_PKT = 64;
    localparam int IDX_W   = $clog2(MAX_PKT);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_sel = '0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic [7:0]       reg_wdata = '0;
    logic             tok_in = 1'b0;
    logic             hs_ack = 1'b0;
    logic             hs_timeout = 1'b0;
    logic             tx_ready = 1'b1;
    logic             tx_valid, tx_last, int_flag_o, irq_o;
    logic [7:0]       tx_data;
    logic [4:0]       ep_ctrl_o;

    usb_in_ep_engine #(.MAX_PKT(MAX_PKT)) u0 (.*);

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit rand_ready = 1'b0;

    logic [7:0] sh_buf [MAX_PKT];
    logic [7:0] cap [MAX_PKT + 8];
    int cap_n = 0;
    int pkt_cnt = 0;

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            report();
        end
    end

    always @(posedge clk) begin
        #1 tx_ready = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            if (cap_n < MAX_PKT + 8) cap[cap_n] = tx_data;
            cap_n = cap_n + 1;
            if (tx_last) pkt_cnt = pkt_cnt + 1;
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int idx, input logic [7:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_idx = IDX_W'(idx); reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    function automatic logic [4:0] cbits(input bit en, ie, tog, stall, nack);
        return {en, ie, tog, stall, nack};
    endfunction

    function automatic logic [7:0] exp_dpid(input bit tog);
        return tog ? 8'h4B : 8'hC3;
    endfunction

    task automatic load(input int n);
        for (int i = 0; i < n; i++) begin
            sh_buf[i] = 8'($urandom);
            wr(2'd2, i, sh_buf[i]);
        end
        wr(2'd1, 0, 8'(n));
    endtask

    // drive a token, check the first byte timing, then wait for the packet
    task automatic token(input string req, input logic [7:0] first);
        int old;
        old = pkt_cnt;
        cap_n = 0;
        tok_in = 1'b1;
        tick();
        tok_in = 1'b0;
        chk(tx_valid && tx_data == first, {req, " R7 first byte"}, {23'd0, tx_valid, tx_data}, {24'd1, first});
        for (int w = 0; w < 600 && pkt_cnt == old; w++) tick();
        chk(pkt_cnt == old + 1, {req, " packet end"}, pkt_cnt, old + 1);
    endtask

    task automatic chk_pkt(input string req, input logic [7:0] pid, input int n);
        int bad;
        chk(cap_n == n + 1, {req, " length"}, cap_n, n + 1);
        chk(cap[0] == pid, {req, " pid"}, cap[0], pid);
        bad = -1;
        for (int i = 0; i < n && i < MAX_PKT; i++)
            if (bad < 0 && cap[i + 1] != sh_buf[i]) bad = i;
        chk(bad < 0, {req, " payload"}, (bad < 0) ? 0 : cap[bad + 1], (bad < 0) ? 0 : sh_buf[bad]);
    endtask

    task automatic hshk(input bit ack);
        if (ack) hs_ack = 1'b1; else hs_timeout = 1'b1;
        tick();
        hs_ack = 1'b0; hs_timeout = 1'b0;
    endtask

    task automatic silent(input string req);
        int old;
        old = pkt_cnt;
        cap_n = 0;
        tok_in = 1'b1;
        tick();
        tok_in = 1'b0;
        for (int w = 0; w < 20; w++) tick();
        chk(pkt_cnt == old && cap_n == 0, req, cap_n, 0);
    endtask

    initial begin
        bit tog;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst = 1'b0;
        tick();

        chk(ep_ctrl_o == 5'b00001, "R1 reset ctrl", ep_ctrl_o, 5'b00001);
        chk(!tx_valid && !int_flag_o && !irq_o, "R1 reset outputs", {tx_valid, int_flag_o, irq_o}, 0);

        // disabled endpoint, even when armed
        wr(2'd0, 0, 8'(cbits(0, 1, 0, 0, 0)));
        chk(ep_ctrl_o == cbits(0, 1, 0, 0, 0), "R2 control write", ep_ctrl_o, cbits(0, 1, 0, 0, 0));
        silent("R3 disabled token ignored");
        chk(ep_ctrl_o == cbits(0, 1, 0, 0, 0), "R3 no state change", ep_ctrl_o, cbits(0, 1, 0, 0, 0));

        // NAK
        wr(2'd0, 0, 8'(cbits(1, 1, 0, 0, 1)));
        token("R5 nak", 8'h5A);
        chk(cap_n == 1 && cap[0] == 8'h5A, "R5 nak packet", cap[0], 8'h5A);
        chk(ep_ctrl_o == cbits(1, 1, 0, 0, 1), "R5 ctrl unchanged", ep_ctrl_o, cbits(1, 1, 0, 0, 1));

        // STALL beats NACK
        wr(2'd0, 0, 8'(cbits(1, 1, 0, 1, 1)));
        token("R4 stall", 8'h1E);
        chk(cap_n == 1 && cap[0] == 8'h1E, "R4 stall packet", cap[0], 8'h1E);
        wr(2'd0, 0, 8'(cbits(1, 1, 0, 1, 0)));
        token("R4 stall armed", 8'h1E);

        // stray handshakes while idle
        hshk(1'b1);
        hshk(1'b0);
        tick();
        chk(ep_ctrl_o == cbits(1, 1, 0, 1, 0) && !int_flag_o, "R13 stray handshake ignored",
            {int_flag_o, ep_ctrl_o}, {1'b0, cbits(1, 1, 0, 1, 0)});

        // armed DATA0, timeout, resend, then ack with interrupt disabled
        load(5);
        wr(2'd0, 0, 8'(cbits(1, 0, 0, 0, 0)));
        token("R6 data0", 8'hC3);
        chk_pkt("R6 data0", 8'hC3, 5);
        hshk(1'b0);
        chk(ep_ctrl_o == cbits(1, 0, 0, 0, 0) && !int_flag_o, "R9 timeout keeps state",
            {int_flag_o, ep_ctrl_o}, {1'b0, cbits(1, 0, 0, 0, 0)});
        token("R9 resend", 8'hC3);
        chk_pkt("R9 resend", 8'hC3, 5);
        hshk(1'b1);
        chk(ep_ctrl_o == cbits(1, 0, 1, 0, 1), "R8 ack update", ep_ctrl_o, cbits(1, 0, 1, 0, 1));
        chk(int_flag_o && !irq_o, "R11 irq gated off", {int_flag_o, irq_o}, 2'b10);
        wr(2'd0, 0, 8'(cbits(1, 1, 1, 0, 1)));
        chk(int_flag_o && irq_o, "R11 flag sticky, irq on", {int_flag_o, irq_o}, 2'b11);
        wr(2'd3, 0, 8'h00);
        chk(int_flag_o, "R11 clear needs bit0", int_flag_o, 1);
        wr(2'd3, 0, 8'h01);
        chk(!int_flag_o && !irq_o, "R11 flag cleared", {int_flag_o, irq_o}, 0);

        // status stage
        wr(2'd1, 0, 8'd0);
        wr(2'd0, 0, 8'(cbits(1, 1, 1, 0, 0)));
        token("R10 status", 8'h4B);
        chk(cap_n == 1 && cap[0] == 8'h4B, "R10 zero-length data1", {cap_n[23:0], cap[0]}, {24'd1, 8'h4B});
        hshk(1'b1);
        chk(ep_ctrl_o == cbits(1, 1, 0, 0, 1), "R8 status ack", ep_ctrl_o, cbits(1, 1, 0, 0, 1));
        wr(2'd3, 0, 8'h01);

        // count limit under backpressure
        rand_ready = 1'b1;
        load(MAX_PKT);
        wr(2'd1, 0, 8'd100);
        wr(2'd0, 0, 8'(cbits(1, 1, 0, 0, 0)));
        token("R12 clamp", 8'hC3);
        chk_pkt("R12 clamp", 8'hC3, MAX_PKT);
        hshk(1'b1);
        wr(2'd3, 0, 8'h01);

        // constrained random transfers
        tog = 1'b1;
        for (int it = 0; it < 40; it++) begin
            int n;
            n = $urandom_range(0, 16);
            load(n);
            if ($urandom_range(0, 3) == 0) tog = ~tog;
            wr(2'd0, 0, 8'(cbits(1, 1, tog, 0, 0)));
            token("R6 random", exp_dpid(tog));
            chk_pkt("R6 random", exp_dpid(tog), n);
            if ($urandom_range(0, 2) == 0) begin
                hshk(1'b0);
                token("R9 random resend", exp_dpid(tog));
                chk_pkt("R9 random resend", exp_dpid(tog), n);
            end
            hshk(1'b1);
            tog = ~tog;
            chk(ep_ctrl_o == cbits(1, 1, tog, 0, 1) && irq_o, "R8 random ack",
                {irq_o, ep_ctrl_o}, {1'b1, cbits(1, 1, tog, 0, 1)});
            wr(2'd3, 0, 8'h01);
        end

        report();
    end

endmodule